// File: doc/BRIEF.md
# Floppy Perpendicular Recording Mode Controller

This block stores the perpendicular-recording settings of a floppy disk controller and turns them into per-drive format parameters for whichever drive is currently selected. A command write loads two global mode bits (a write-gate-timing bit and a gap bit), an overwrite enable and one perpendicular flag per drive. From these, the drive select and the programmed data rate, the block produces four registered results: whether the selected drive records perpendicularly, the Gap2 length of the format, the number of Gap2 bytes a write-data operation lays down, and a flag that forces write pre-compensation to zero. A perpendicular drive opens its write gate inside Gap2 instead of at the start of the sync field, and that timing follows from the perpendicular output.

The block also holds a lock bit and the FIFO configuration fields: a FIFO-disable flag, a FIFO threshold and a precompensation start track. A software reset clears the global mode bits but keeps the per-drive flags. It restores the FIFO fields only while the lock bit is clear. A hardware reset returns everything to conventional mode and to the defaults.

Top module: `fdc_perp_mode`

## Requirements
- R1: The stored pair {wgate, gap} selects the global mode: 2'b11 is perpendicular at 1 Mbps, 2'b10 is perpendicular at 500 Kbps, and 2'b01 (reserved) and 2'b00 are both conventional.
- R2: `gap2_len_o` is 41 when the selected drive runs perpendicular at 1 Mbps, and 22 in every other case.
- R3: `gap2_wr_o` is 38 for 1 Mbps perpendicular, 19 for 500 Kbps perpendicular and 0 for conventional.
- R4: Per-drive flags (`cmd_drv[i]` belongs to drive i) apply only while wgate and gap are both 0. A flagged drive runs perpendicular at 1 Mbps when `rate_sel` is 2'b11 and at 500 Kbps when it is 2'b00; rates 2'b01 and 2'b10 leave it conventional. When either global bit is 1, the flags are ignored.
- R5: A command write updates the per-drive flags only when `cmd_ow` is 1. Otherwise the flags keep their previous values, while wgate and gap are still loaded.
- R6: A software reset clears wgate and gap, leaves the per-drive flags unchanged, and overrides any command, lock or configuration write in the same cycle.
- R7: A hardware reset clears wgate, gap, all per-drive flags and the lock bit, and sets `efifo_o`=1, `fifothr_o`=0, `pretrk_o`=0.
- R8: `precomp_zero_o` is 1 exactly when `perp_o` is 1.
- R9: With the lock bit at 1, a software reset leaves `efifo_o`, `fifothr_o` and `pretrk_o` unchanged. With the lock bit at 0, it returns them to 1, 0 and 0.
- R10: The decoded outputs are registered. They reflect a command or reset on the second rising edge after the strobe, and a change of `drv_sel` or `rate_sel` on the first edge. The FIFO fields follow one edge after their write or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Synchronous hardware reset, active high |
| sw_rst | input | 1 | Software reset strobe |
| cmd_we | input | 1 | Mode command write strobe |
| cmd_gap | input | 1 | Gap bit of the command |
| cmd_wgate | input | 1 | Write-gate bit of the command |
| cmd_ow | input | 1 | Overwrite enable for the per-drive flags |
| cmd_drv | input | 4 | Per-drive perpendicular flags, bit i for drive i |
| lock_we | input | 1 | Lock bit write strobe |
| lock_val | input | 1 | Lock bit value |
| cfg_we | input | 1 | FIFO configuration write strobe |
| cfg_efifo | input | 1 | FIFO-disable flag to load |
| cfg_fifothr | input | 4 | FIFO threshold to load |
| cfg_pretrk | input | 8 | Precompensation start track to load |
| rate_sel | input | 2 | Programmed data rate code |
| drv_sel | input | 2 | Selected drive |
| perp_o | output | 1 | Selected drive records perpendicular |
| gap2_len_o | output | 6 | Gap2 format length in bytes |
| gap2_wr_o | output | 6 | Gap2 bytes written by a write-data operation |
| precomp_zero_o | output | 1 | Force write pre-compensation to zero |
| efifo_o | output | 1 | FIFO-disable flag |
| fifothr_o | output | 4 | FIFO threshold |
| pretrk_o | output | 8 | Precompensation start track |

## Verification
A command, software reset or hardware reset is first captured in the mode registers and then passes through the output register. Its effect on the four decoded results is therefore due on the second rising edge. A new drive select or rate needs only the output register and is due on the first edge. The FIFO fields are due one edge after their strobe. The bench applies every stimulus for one edge, waits one more edge, and only then samples all outputs at the following falling edge, so every result is compared after its latest possible update and before the next stimulus.

// File: rtl/fdc_perp_pkg.sv
package fdc_perp_pkg;
   typedef enum logic [1:0] {
      MODE_CONV = 2'd0,
      MODE_P500 = 2'd1,
      MODE_P1M  = 2'd2
   } perp_mode_e;

   localparam logic [1:0] RATE_500K = 2'b00;
   localparam logic [1:0] RATE_1M   = 2'b11;

   function automatic perp_mode_e global_mode(input logic wgate, input logic gap);
      case ({wgate, gap})
         2'b11:   return MODE_P1M;
         2'b10:   return MODE_P500;
         default: return MODE_CONV;
      endcase
   endfunction

   function automatic perp_mode_e rate_mode(input logic [1:0] rate);
      if (rate == RATE_1M)   return MODE_P1M;
      if (rate == RATE_500K) return MODE_P500;
      return MODE_CONV;
   endfunction
endpackage

// File: rtl/fdc_perp_regs.sv
module fdc_perp_regs #(
   parameter int NUM_DRV   = 4,
   parameter int THR_W     = 4,
   parameter int PRE_W     = 8,
   parameter bit EFIFO_DEF = 1'b1
) (
   input  logic               clk,
   input  logic               hw_rst,
   input  logic               sw_rst,
   input  logic               cmd_we,
   input  logic               cmd_gap,
   input  logic               cmd_wgate,
   input  logic               cmd_ow,
   input  logic [NUM_DRV-1:0] cmd_drv,
   input  logic               lock_we,
   input  logic               lock_val,
   input  logic               cfg_we,
   input  logic               cfg_efifo,
   input  logic [THR_W-1:0]   cfg_thr,
   input  logic [PRE_W-1:0]   cfg_pre,
   output logic               gap_q,
   output logic               wgate_q,
   output logic [NUM_DRV-1:0] drv_q,
   output logic               lock_q,
   output logic               efifo_q,
   output logic [THR_W-1:0]   thr_q,
   output logic [PRE_W-1:0]   pre_q
);
   logic drv_load;
   logic cfg_restore;

   assign drv_load    = cmd_we & cmd_ow & ~sw_rst;
   assign cfg_restore = sw_rst & ~lock_q;

   always_ff @(posedge clk) begin
      if (hw_rst || sw_rst) begin
         gap_q   <= 1'b0;
         wgate_q <= 1'b0;
      end else if (cmd_we) begin
         gap_q   <= cmd_gap;
         wgate_q <= cmd_wgate;
      end
   end

   for (genvar i = 0; i < NUM_DRV; i++) begin : g_drv
      always_ff @(posedge clk) begin
         if (hw_rst)        drv_q[i] <= 1'b0;
         else if (drv_load) drv_q[i] <= cmd_drv[i];
      end
   end

   always_ff @(posedge clk) begin
      if (hw_rst)                   lock_q <= 1'b0;
      else if (lock_we && !sw_rst)  lock_q <= lock_val;
   end

   always_ff @(posedge clk) begin
      if (hw_rst || cfg_restore) begin
         efifo_q <= EFIFO_DEF;
         thr_q   <= '0;
         pre_q   <= '0;
      end else if (cfg_we && !sw_rst) begin
         efifo_q <= cfg_efifo;
         thr_q   <= cfg_thr;
         pre_q   <= cfg_pre;
      end
   end

   p_ow_hold_r5: assert property (@(posedge clk) disable iff (hw_rst)
      (cmd_we && !cmd_ow) |=> $stable(drv_q));
   p_sw_keep_r6: assert property (@(posedge clk) disable iff (hw_rst)
      sw_rst |=> ($stable(drv_q) && !gap_q && !wgate_q));
   p_hw_clear_r7: assert property (@(posedge clk)
      hw_rst |=> (drv_q == '0 && !lock_q && efifo_q == EFIFO_DEF && thr_q == '0 && pre_q == '0));
   p_lock_hold_r9: assert property (@(posedge clk) disable iff (hw_rst)
      (sw_rst && lock_q) |=> ($stable(efifo_q) && $stable(thr_q) && $stable(pre_q)));
endmodule

// File: rtl/fdc_perp_decode.sv
module fdc_perp_decode
   import fdc_perp_pkg::*;
#(
   parameter int NUM_DRV   = 4,
   parameter int LEN_W     = 6,
   parameter int GAP2_STD  = 22,
   parameter int GAP2_LONG = 41,
   parameter int WR_500K   = 19,
   parameter int WR_1M     = 38,
   localparam int SEL_W    = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
   input  logic               clk,
   input  logic               hw_rst,
   input  logic               gap_q,
   input  logic               wgate_q,
   input  logic [NUM_DRV-1:0] drv_q,
   input  logic [SEL_W-1:0]   drv_sel,
   input  logic [1:0]         rate_sel,
   output logic               perp_o,
   output logic [LEN_W-1:0]   gap2_len_o,
   output logic [LEN_W-1:0]   gap2_wr_o,
   output logic               precomp_zero_o
);
   localparam logic [LEN_W-1:0] LEN_STD  = LEN_W'(GAP2_STD);
   localparam logic [LEN_W-1:0] LEN_LONG = LEN_W'(GAP2_LONG);
   localparam logic [LEN_W-1:0] CNT_500  = LEN_W'(WR_500K);
   localparam logic [LEN_W-1:0] CNT_1M   = LEN_W'(WR_1M);

   perp_mode_e g_mode, eff_mode;
   logic       drv_flag;

   assign drv_flag = (int'(drv_sel) < NUM_DRV) ? drv_q[drv_sel] : 1'b0;

   always_comb begin
      g_mode = global_mode(wgate_q, gap_q);
      if (!wgate_q && !gap_q && drv_flag) eff_mode = rate_mode(rate_sel);
      else                                eff_mode = g_mode;
   end

   always_ff @(posedge clk) begin
      if (hw_rst) begin
         perp_o         <= 1'b0;
         precomp_zero_o <= 1'b0;
         gap2_len_o     <= LEN_STD;
         gap2_wr_o      <= '0;
      end else begin
         perp_o         <= (eff_mode != MODE_CONV);
         precomp_zero_o <= (eff_mode == MODE_P500) || (eff_mode == MODE_P1M);
         gap2_len_o     <= (eff_mode == MODE_P1M) ? LEN_LONG : LEN_STD;
         case (eff_mode)
            MODE_P1M:  gap2_wr_o <= CNT_1M;
            MODE_P500: gap2_wr_o <= CNT_500;
            default:   gap2_wr_o <= '0;
         endcase
      end
   end

   p_reserved_conv_r1: assert property (@(posedge clk) disable iff (hw_rst)
      (gap_q && !wgate_q) |=> !perp_o);
   p_long_pair_r2: assert property (@(posedge clk) disable iff (hw_rst)
      (gap2_len_o == LEN_LONG) |-> (gap2_wr_o == CNT_1M));
   p_wr_zero_r3: assert property (@(posedge clk) disable iff (hw_rst)
      !perp_o |-> (gap2_wr_o == '0 && gap2_len_o == LEN_STD));
   p_pz_match_r8: assert property (@(posedge clk) disable iff (hw_rst)
      precomp_zero_o == perp_o);
   p_flag_ignored_r4: assert property (@(posedge clk) disable iff (hw_rst)
      (wgate_q && !gap_q) |=> (gap2_wr_o == CNT_500));
endmodule

// File: rtl/fdc_perp_mode.sv
module fdc_perp_mode #(
   parameter int NUM_DRV   = 4,
   parameter int LEN_W     = 6,
   parameter int THR_W     = 4,
   parameter int PRE_W     = 8,
   parameter int GAP2_STD  = 22,
   parameter int GAP2_LONG = 41,
   parameter int WR_500K   = 19,
   parameter int WR_1M     = 38,
   parameter bit EFIFO_DEF = 1'b1,
   localparam int SEL_W    = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
   input  logic               clk,
   input  logic               hw_rst,
   input  logic               sw_rst,
   input  logic               cmd_we,
   input  logic               cmd_gap,
   input  logic               cmd_wgate,
   input  logic               cmd_ow,
   input  logic [NUM_DRV-1:0] cmd_drv,
   input  logic               lock_we,
   input  logic               lock_val,
   input  logic               cfg_we,
   input  logic               cfg_efifo,
   input  logic [THR_W-1:0]   cfg_fifothr,
   input  logic [PRE_W-1:0]   cfg_pretrk,
   input  logic [1:0]         rate_sel,
   input  logic [SEL_W-1:0]   drv_sel,
   output logic               perp_o,
   output logic [LEN_W-1:0]   gap2_len_o,
   output logic [LEN_W-1:0]   gap2_wr_o,
   output logic               precomp_zero_o,
   output logic               efifo_o,
   output logic [THR_W-1:0]   fifothr_o,
   output logic [PRE_W-1:0]   pretrk_o
);
   if (GAP2_LONG >= (1 << LEN_W) || GAP2_STD >= (1 << LEN_W)) begin : g_bad_len
      $error("LEN_W too narrow for the Gap2 lengths");
   end
   if (WR_1M > GAP2_LONG || WR_500K > GAP2_STD) begin : g_bad_cnt
      $error("written Gap2 count exceeds the Gap2 length");
   end
   if (NUM_DRV < 1) begin : g_bad_drv
      $error("NUM_DRV must be at least 1");
   end

   logic               gap_q, wgate_q, lock_q;
   logic [NUM_DRV-1:0] drv_q;

   fdc_perp_regs #(
      .NUM_DRV(NUM_DRV), .THR_W(THR_W), .PRE_W(PRE_W), .EFIFO_DEF(EFIFO_DEF)
   ) regs_i (
      .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst),
      .cmd_we(cmd_we), .cmd_gap(cmd_gap), .cmd_wgate(cmd_wgate), .cmd_ow(cmd_ow),
      .cmd_drv(cmd_drv), .lock_we(lock_we), .lock_val(lock_val),
      .cfg_we(cfg_we), .cfg_efifo(cfg_efifo), .cfg_thr(cfg_fifothr), .cfg_pre(cfg_pretrk),
      .gap_q(gap_q), .wgate_q(wgate_q), .drv_q(drv_q), .lock_q(lock_q),
      .efifo_q(efifo_o), .thr_q(fifothr_o), .pre_q(pretrk_o)
   );

   fdc_perp_decode #(
      .NUM_DRV(NUM_DRV), .LEN_W(LEN_W), .GAP2_STD(GAP2_STD), .GAP2_LONG(GAP2_LONG),
      .WR_500K(WR_500K), .WR_1M(WR_1M)
   ) dec_i (
      .clk(clk), .hw_rst(hw_rst), .gap_q(gap_q), .wgate_q(wgate_q), .drv_q(drv_q),
      .drv_sel(drv_sel), .rate_sel(rate_sel),
      .perp_o(perp_o), .gap2_len_o(gap2_len_o), .gap2_wr_o(gap2_wr_o),
      .precomp_zero_o(precomp_zero_o)
   );
endmodule

// File: tb/fdc_perp_mode_tb_top.sv
module fdc_perp_mode_tb_top;
   logic       clk = 1'b0;
   logic       hw_rst = 1'b1, sw_rst = 1'b0, cmd_we = 1'b0, cmd_gap = 1'b0;
   logic       cmd_wgate = 1'b0, cmd_ow = 1'b0, lock_we = 1'b0, lock_val = 1'b0;
   logic       cfg_we = 1'b0, cfg_efifo = 1'b0;
   logic [3:0] cmd_drv = '0, cfg_fifothr = '0;
   logic [7:0] cfg_pretrk = '0;
   logic [1:0] rate_sel = '0, drv_sel = '0;
   logic       perp_o, precomp_zero_o, efifo_o;
   logic [5:0] gap2_len_o, gap2_wr_o;
   logic [3:0] fifothr_o;
   logic [7:0] pretrk_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // bench model
   bit m_gap, m_wg, m_lock, m_ef;
   bit [3:0] m_drv, m_thr;
   bit [7:0] m_pre;

   always #2 clk = ~clk;

   fdc_perp_mode dut_i (
      .clk(clk), .hw_rst(hw_rst), .sw_rst(sw_rst), .cmd_we(cmd_we), .cmd_gap(cmd_gap),
      .cmd_wgate(cmd_wgate), .cmd_ow(cmd_ow), .cmd_drv(cmd_drv), .lock_we(lock_we),
      .lock_val(lock_val), .cfg_we(cfg_we), .cfg_efifo(cfg_efifo), .cfg_fifothr(cfg_fifothr),
      .cfg_pretrk(cfg_pretrk), .rate_sel(rate_sel), .drv_sel(drv_sel), .perp_o(perp_o),
      .gap2_len_o(gap2_len_o), .gap2_wr_o(gap2_wr_o), .precomp_zero_o(precomp_zero_o),
      .efifo_o(efifo_o), .fifothr_o(fifothr_o), .pretrk_o(pretrk_o)
   );

   // 0 conventional, 1 = 500K, 2 = 1M
   function automatic int exp_mode();
      if (m_wg && m_gap) return 2;
      if (m_wg && !m_gap) return 1;
      if (m_gap) return 0;
      if (!m_drv[drv_sel]) return 0;
      if (rate_sel == 2'b11) return 2;
      if (rate_sel == 2'b00) return 1;
      return 0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      int m = exp_mode();
      chk({tag, " R1/R4 perp"}, perp_o, m != 0);
      chk({tag, " R2 len"}, gap2_len_o, (m == 2) ? 41 : 22);
      chk({tag, " R3 wr"}, gap2_wr_o, (m == 2) ? 38 : (m == 1) ? 19 : 0);
      chk({tag, " R8 pz"}, precomp_zero_o, m != 0);
      chk({tag, " R9 efifo"}, efifo_o, m_ef);
      chk({tag, " R9 thr"}, fifothr_o, m_thr);
      chk({tag, " R9 pre"}, pretrk_o, m_pre);
   endtask

   // apply strobes for one edge, wait a second edge (R10), sample at negedge
   task automatic apply();
      @(posedge clk);
      if (hw_rst) begin
         m_gap = 0; m_wg = 0; m_drv = 0; m_lock = 0; m_ef = 1; m_thr = 0; m_pre = 0;
      end else if (sw_rst) begin
         m_gap = 0; m_wg = 0;
         if (!m_lock) begin m_ef = 1; m_thr = 0; m_pre = 0; end
      end else begin
         if (cmd_we) begin
            m_gap = cmd_gap; m_wg = cmd_wgate;
            if (cmd_ow) m_drv = cmd_drv;
         end
         if (lock_we) m_lock = lock_val;
         if (cfg_we) begin m_ef = cfg_efifo; m_thr = cfg_fifothr; m_pre = cfg_pretrk; end
      end
      #1;
      hw_rst = 0; sw_rst = 0; cmd_we = 0; lock_we = 0; cfg_we = 0;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic cmd(input bit wg, input bit g, input bit ow, input bit [3:0] d);
      cmd_we = 1; cmd_wgate = wg; cmd_gap = g; cmd_ow = ow; cmd_drv = d;
      apply();
   endtask

   initial begin
      apply();
      check_all("reset R7");
      // R1 global codes
      cmd(1, 1, 1, 4'h0); check_all("1M R1");
      cmd(1, 0, 0, 4'h0); check_all("500K R1");
      cmd(0, 1, 0, 4'h0); check_all("reserved R1");
      // R4 per-drive with rate
      cmd(0, 0, 1, 4'b0101);
      for (int s = 0; s < 4; s++) begin
         for (int r = 0; r < 4; r++) begin
            drv_sel = 2'(s); rate_sel = 2'(r);
            @(posedge clk); @(negedge clk);
            check_all("drive/rate R4 R10");
         end
      end
      // R4 flags ignored under reserved code
      drv_sel = 0; rate_sel = 2'b11;
      cmd(0, 1, 0, 4'h0); check_all("ignored R4");
      // R5 no overwrite
      cmd(0, 0, 0, 4'h0); check_all("ow0 R5");
      // R6 sw reset keeps flags, wins over write
      cmd(1, 1, 0, 4'h0);
      sw_rst = 1; cmd_we = 1; cmd_wgate = 1; cmd_gap = 1; cmd_ow = 1; cmd_drv = 4'h0;
      apply(); check_all("sw R6");
      // R9 lock
      cfg_we = 1; cfg_efifo = 0; cfg_fifothr = 4'h9; cfg_pretrk = 8'h5A; lock_we = 1; lock_val = 1;
      apply(); check_all("cfg R9");
      sw_rst = 1; apply(); check_all("locked R9");
      lock_we = 1; lock_val = 0; apply();
      sw_rst = 1; apply(); check_all("unlocked R9");
      // R7 hw reset clears flags
      cmd(0, 0, 1, 4'hF); hw_rst = 1; apply(); check_all("hw R7");
      // random mix
      void'($urandom(32'd1234));
      for (int k = 0; k < 400; k++) begin
         int op = $urandom_range(0, 9);
         drv_sel = 2'($urandom); rate_sel = 2'($urandom);
         if (op < 5) begin
            cmd_we = 1; cmd_wgate = 1'($urandom); cmd_gap = 1'($urandom);
            cmd_ow = 1'($urandom); cmd_drv = 4'($urandom);
         end else if (op == 5) sw_rst = 1;
         else if (op == 6) begin lock_we = 1; lock_val = 1'($urandom); end
         else if (op == 7) begin
            cfg_we = 1; cfg_efifo = 1'($urandom); cfg_fifothr = 4'($urandom); cfg_pretrk = 8'($urandom);
         end else if (op == 8 && k % 7 == 0) hw_rst = 1;
         apply();
         check_all("random R1 R3 R6 R10");
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule